// File: doc/BRIEF.md
# Truth-Table Logic Unit with Conditional Load

This block is the logical and conditional-move slice of a small 16-bit datapath. For each instruction it takes a destination operand, a source operand, a 2-bit operation code and a 4-bit truth-table field. It returns the value to write back and a write enable. Four status flags live inside the block: sign, nonzero, carry and overflow.

In the bitwise mode, the truth-table field is a programmable two-input function. Each result bit is the table entry selected by the pair formed from the destination bit and the source bit at that position. In the two conditional-load modes, the same field is a truth table over a pair of flags. The source is written back only when the selected entry is 1. The write-back value and enable are combinational. The flags are registered.

Carry and overflow are not computed here. An arithmetic unit beside this block supplies them through a dedicated update port. A run input held low stops all writes and clears every flag.

Top module: `tt_logic_unit`

## Requirements
- R1: When `rst_n` is low at a rising edge, all four flags read 0 after that edge. With `in_valid` low, `wr_en` is 0.
- R2: For operation code 0 (bitwise), each result bit k is `tt_mod[{dst_val[k], src_val[k]}]`. Here `tt_mod[3]` is the entry for (1,1), `tt_mod[2]` for (1,0), `tt_mod[1]` for (0,1) and `tt_mod[0]` for (0,0). `wr_en` is 1 in the same cycle.
- R3: After a valid bitwise operation, the next rising edge sets `flag_s` to result bit 15 and `flag_n` to the OR of result bits 14..0.
- R4: A bitwise operation leaves `flag_k` and `flag_v` unchanged.
- R5: Operation code 2 loads the source when `tt_mod[{flag_s, flag_n}]` is 1. A load gives `res_val = src_val` and `wr_en = 1`. The operation never changes `flag_s` or `flag_n`.
- R6: Operation code 3 loads the source when `tt_mod[{flag_k, flag_v}]` is 1.
- R7: When a conditional load's selected table entry is 0, `wr_en` is 0 and `res_val` equals `dst_val`.
- R8: `kv_upd` high at a rising edge loads `kv_k` and `kv_v` into `flag_k` and `flag_v`.
- R9: With `run` low, `wr_en` is 0 and `res_val` is 0 in the same cycle. All four flags are 0 after the next rising edge, even if `kv_upd` is high.
- R10: Operation code 1 (arithmetic, handled elsewhere) and cycles with `in_valid` low give `wr_en = 0` and `res_val = dst_val`. They leave `flag_s` and `flag_n` unchanged.
- R11: A conditional load with `tt_mod = 4'b1111` always loads, whatever the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Low: block writes nothing and clears flags |
| in_valid | input | 1 | Instruction present this cycle |
| op_code | input | 2 | 0 bitwise, 1 arithmetic, 2 load on S/N, 3 load on K/V |
| tt_mod | input | 4 | Truth-table field |
| dst_val | input | 16 | Current destination value |
| src_val | input | 16 | Source value |
| kv_upd | input | 1 | Load carry and overflow from the arithmetic unit |
| kv_k | input | 1 | New carry value |
| kv_v | input | 1 | New overflow value |
| res_val | output | 16 | Write-back value |
| wr_en | output | 1 | Destination write enable |
| flag_s | output | 1 | Sign flag |
| flag_n | output | 1 | Nonzero flag |
| flag_k | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
`res_val` and `wr_en` follow the inputs in the same cycle. The bench drives inputs just after a falling edge and samples these outputs one nanosecond later, before the next rising edge. Flags change only at the rising edge that follows the stimulus, so the bench reads them at the next falling edge. A conditional load therefore always sees the flags that were set by the instruction one cycle earlier.

// File: rtl/tt_pkg.sv
// Package: shared operation codes for the truth-table logic unit.
// Assumes a 2-bit operation field; code 1 belongs to an external arithmetic unit.
package tt_pkg;
    typedef enum logic [1:0] {
        OP_BITWISE = 2'd0,
        OP_ARITH   = 2'd1,
        OP_LOAD_SN = 2'd2,
        OP_LOAD_KV = 2'd3
    } tt_op_e;

    localparam int TT_ENTRIES = 4;
endpackage

// File: rtl/tt_bitwise.sv
// Module: per-bit programmable two-input function.
// Each output bit selects one of four table entries, indexed by
// {destination bit, source bit}. Purely combinational.
module tt_bitwise #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] dst_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic [3:0]       table_i,
    output logic [WIDTH-1:0] out_o
);
    // one 4:1 table lookup per bit position
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign out_o[b] = table_i[{dst_i[b], src_i[b]}];
    end

    // guard: the copy table must reproduce the source (R2)
    always_comb begin
        if (table_i == 4'b1010) begin
            p_copy_src_r2: assert (out_o == src_i);
        end
    end
endmodule

// File: rtl/tt_cond_sel.sv
// Module: conditional-load decision.
// Picks the flag pair named by the operation code and looks it up in the
// truth table. Assumes the caller qualifies the result with valid and run.
module tt_cond_sel
    import tt_pkg::*;
(
    input  tt_op_e     op_i,
    input  logic [3:0] table_i,
    input  logic       s_i,
    input  logic       n_i,
    input  logic       k_i,
    input  logic       v_i,
    output logic       is_load_o,
    output logic       hit_o
);
    logic [1:0] pair;

    // choose which flag pair indexes the table
    always_comb begin
        pair      = {s_i, n_i};
        is_load_o = 1'b0;
        case (op_i)
            OP_LOAD_SN: begin pair = {s_i, n_i}; is_load_o = 1'b1; end
            OP_LOAD_KV: begin pair = {k_i, v_i}; is_load_o = 1'b1; end
            default:    begin pair = {s_i, n_i}; is_load_o = 1'b0; end
        endcase
    end

    // table lookup, meaningful only for the load codes
    assign hit_o = is_load_o & table_i[pair];

    // an all-ones table must always hit (R11)
    always_comb begin
        if (is_load_o && table_i == 4'b1111) begin
            p_full_table_hits_r11: assert (hit_o);
        end
    end
endmodule

// File: rtl/tt_flag_reg.sv
// Module: status flag storage.
// Sign/nonzero load from a bitwise result; carry/overflow load from the
// external arithmetic port. Synchronous active-low reset; run low clears all.
module tt_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sn_upd,
    input  logic sn_s,
    input  logic sn_n,
    input  logic kv_upd,
    input  logic kv_k,
    input  logic kv_v,
    output logic s_o,
    output logic n_o,
    output logic k_o,
    output logic v_o
);
    // flag update with reset and run-stop clearing
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            s_o <= 1'b0;
            n_o <= 1'b0;
            k_o <= 1'b0;
            v_o <= 1'b0;
        end else begin
            if (sn_upd) begin
                s_o <= sn_s;
                n_o <= sn_n;
            end
            if (kv_upd) begin
                k_o <= kv_k;
                v_o <= kv_v;
            end
        end
    end

    // external port lands in carry/overflow one edge later (R8)
    p_kv_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kv_upd && run) |=> (k_o == $past(kv_k) && v_o == $past(kv_v)));
endmodule

// File: rtl/tt_logic_unit.sv
// Module: top of the truth-table logic unit.
// Combinational write-back value and enable; registered flags.
// Assumes the caller writes res_val into the destination when wr_en is high.
module tt_logic_unit
    import tt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             in_valid,
    input  logic [1:0]       op_code,
    input  logic [3:0]       tt_mod,
    input  logic [WIDTH-1:0] dst_val,
    input  logic [WIDTH-1:0] src_val,
    input  logic             kv_upd,
    input  logic             kv_k,
    input  logic             kv_v,
    output logic [WIDTH-1:0] res_val,
    output logic             wr_en,
    output logic             flag_s,
    output logic             flag_n,
    output logic             flag_k,
    output logic             flag_v
);
    localparam int MSB = WIDTH - 1;

    tt_op_e           op;
    logic [WIDTH-1:0] bit_res;
    logic             is_load;
    logic             hit;
    logic             do_bitwise;
    logic             do_load;

    assign op = tt_op_e'(op_code);

    tt_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .dst_i   (dst_val),
        .src_i   (src_val),
        .table_i (tt_mod),
        .out_o   (bit_res)
    );

    tt_cond_sel u_cond (
        .op_i      (op),
        .table_i   (tt_mod),
        .s_i       (flag_s),
        .n_i       (flag_n),
        .k_i       (flag_k),
        .v_i       (flag_v),
        .is_load_o (is_load),
        .hit_o     (hit)
    );

    // qualify the two writing paths with valid and run
    assign do_bitwise = in_valid && run && (op == OP_BITWISE);
    assign do_load    = in_valid && run && hit;

    // write-back value and enable
    always_comb begin
        if (!run) begin
            res_val = '0;
            wr_en   = 1'b0;
        end else if (do_bitwise) begin
            res_val = bit_res;
            wr_en   = 1'b1;
        end else if (do_load) begin
            res_val = src_val;
            wr_en   = 1'b1;
        end else begin
            res_val = dst_val;
            wr_en   = 1'b0;
        end
    end

    tt_flag_reg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .sn_upd (do_bitwise),
        .sn_s   (bit_res[MSB]),
        .sn_n   (|bit_res[MSB-1:0]),
        .kv_upd (kv_upd),
        .kv_k   (kv_k),
        .kv_v   (kv_v),
        .s_o    (flag_s),
        .n_o    (flag_n),
        .k_o    (flag_k),
        .v_o    (flag_v)
    );

    // bitwise result sets sign and nonzero at the next edge (R3)
    p_bitwise_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && run && op_code == 2'd0) |=>
        (flag_s == $past(res_val[MSB]) && flag_n == $past(|res_val[MSB-1:0])));

    // bitwise operation keeps carry and overflow (R4)
    p_bitwise_keeps_kv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && run && op_code == 2'd0 && !kv_upd) |=> $stable({flag_k, flag_v}));

    // sign/nonzero load never touches sign/nonzero (R5)
    p_load_keeps_sn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && run && op_code == 2'd2) |=> $stable({flag_s, flag_n}));

    // a failed conditional load writes nothing and passes dst through (R7)
    p_fail_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && run && is_load && !hit) |-> (!wr_en && res_val == dst_val));

    // run low clears all flags at the next edge (R9)
    p_run_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ({flag_s, flag_n, flag_k, flag_v} == 4'b0000));
endmodule

// File: tb/tt_logic_unit_tb.sv
`timescale 1ns/1ps
module tt_logic_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n, run, in_valid, kv_upd, kv_k, kv_v;
    logic [1:0]  op_code;
    logic [3:0]  tt_mod;
    logic [15:0] dst_val, src_val, res_val;
    logic        wr_en, flag_s, flag_n, flag_k, flag_v;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tt_logic_unit u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .in_valid(in_valid),
        .op_code(op_code), .tt_mod(tt_mod), .dst_val(dst_val), .src_val(src_val),
        .kv_upd(kv_upd), .kv_k(kv_k), .kv_v(kv_v),
        .res_val(res_val), .wr_en(wr_en),
        .flag_s(flag_s), .flag_n(flag_n), .flag_k(flag_k), .flag_v(flag_v)
    );

    // {table, dst, src, expected result, expected S, expected N}
    localparam logic [53:0] VEC [0:8] = '{
        {4'b1010, 16'h1234, 16'hABCD, 16'hABCD, 1'b1, 1'b1},
        {4'b0110, 16'hFF00, 16'h0F0F, 16'hF00F, 1'b1, 1'b1},
        {4'b0011, 16'h00FF, 16'h1234, 16'hFF00, 1'b1, 1'b1},
        {4'b1000, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b0, 1'b1},
        {4'b1110, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0},
        {4'b0000, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
        {4'b1111, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b1},
        {4'b1010, 16'h0000, 16'h8000, 16'h8000, 1'b1, 1'b0},
        {4'b1010, 16'hFFFF, 16'h0001, 16'h0001, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [3:0] m,
                         input logic [15:0] d, input logic [15:0] s);
        in_valid = v; op_code = op; tt_mod = m; dst_val = d; src_val = s;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        rst_n = 1'b0; run = 1'b1; kv_upd = 1'b0; kv_k = 1'b0; kv_v = 1'b0;
        drive(1'b0, 2'd0, 4'b0000, 16'h0, 16'h0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 flags", {flag_s, flag_n, flag_k, flag_v}, 4'b0000);
        chk("R1 wr_en", wr_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R4: truth-table vectors
        for (int i = 0; i < 9; i++) begin
            drive(1'b1, 2'd0, VEC[i][53:50], VEC[i][49:34], VEC[i][33:18]);
            #1;
            chk("R2 result", res_val, VEC[i][17:2]);
            chk("R2 wr_en", wr_en, 1'b1);
            @(negedge clk);
            chk("R3 sign/nonzero", {flag_s, flag_n}, VEC[i][1:0]);
            chk("R4 carry/overflow", {flag_k, flag_v}, 2'b00);
        end

        // R8 external update, R10 valid low
        drive(1'b0, 2'd0, 4'b1111, 16'h5A5A, 16'h1111);
        kv_upd = 1'b1; kv_k = 1'b1; kv_v = 1'b0;
        #1;
        chk("R10 idle wr_en", wr_en, 1'b0);
        chk("R10 idle result", res_val, 16'h5A5A);
        @(negedge clk);
        kv_upd = 1'b0;
        chk("R8 carry/overflow", {flag_k, flag_v}, 2'b10);
        chk("R10 idle keeps S/N", {flag_s, flag_n}, 2'b01);

        // R4: copy 8000 -> S=1 N=0, K/V unchanged
        drive(1'b1, 2'd0, 4'b1010, 16'h0000, 16'h8000);
        @(negedge clk);
        chk("R4 keeps K/V", {flag_k, flag_v}, 2'b10);
        chk("R3 S1 N0", {flag_s, flag_n}, 2'b10);

        // R5: load on S/N, entry (1,0) = bit 2
        drive(1'b1, 2'd2, 4'b0100, 16'h1111, 16'h2222);
        #1;
        chk("R5 load result", res_val, 16'h2222);
        chk("R5 load wr_en", wr_en, 1'b1);
        @(negedge clk);
        chk("R5 S/N unchanged", {flag_s, flag_n}, 2'b10);

        // R7: failing S/N load
        drive(1'b1, 2'd2, 4'b1011, 16'h3333, 16'h4444);
        #1;
        chk("R7 fail wr_en", wr_en, 1'b0);
        chk("R7 fail result", res_val, 16'h3333);
        @(negedge clk);

        // R6: load on K/V (K=1 V=0 -> bit 2)
        drive(1'b1, 2'd3, 4'b0100, 16'h5555, 16'h6666);
        #1;
        chk("R6 load result", res_val, 16'h6666);
        chk("R6 load wr_en", wr_en, 1'b1);
        @(negedge clk);
        drive(1'b1, 2'd3, 4'b1011, 16'h7777, 16'h8888);
        #1;
        chk("R7 K/V fail wr_en", wr_en, 1'b0);
        chk("R7 K/V fail result", res_val, 16'h7777);
        @(negedge clk);

        // R10: arithmetic code ignored here
        drive(1'b1, 2'd1, 4'b1111, 16'h9999, 16'hAAAA);
        #1;
        chk("R10 arith wr_en", wr_en, 1'b0);
        chk("R10 arith result", res_val, 16'h9999);
        @(negedge clk);
        chk("R10 arith keeps S/N", {flag_s, flag_n}, 2'b10);

        // R9: run low clears, even with kv_upd
        run = 1'b0; kv_upd = 1'b1; kv_k = 1'b1; kv_v = 1'b1;
        drive(1'b1, 2'd0, 4'b1010, 16'hBBBB, 16'hCCCC);
        #1;
        chk("R9 run-low wr_en", wr_en, 1'b0);
        chk("R9 run-low result", res_val, 16'h0000);
        @(negedge clk);
        chk("R9 flags cleared", {flag_s, flag_n, flag_k, flag_v}, 4'b0000);
        run = 1'b1; kv_upd = 1'b0;

        // R11: full table always loads, flags all zero
        drive(1'b1, 2'd2, 4'b1111, 16'h0101, 16'h0202);
        #1;
        chk("R11 S/N full table", {wr_en, res_val}, {1'b1, 16'h0202});
        @(negedge clk);
        drive(1'b1, 2'd3, 4'b1111, 16'h0303, 16'h0404);
        #1;
        chk("R11 K/V full table", {wr_en, res_val}, {1'b1, 16'h0404});
        @(negedge clk);
        // R7: flags zero select entry 0, which is 0 here
        drive(1'b1, 2'd2, 4'b1110, 16'h0505, 16'h0606);
        #1;
        chk("R7 entry0 fail", {wr_en, res_val}, {1'b0, 16'h0505});
        @(negedge clk);
        drive(1'b0, 2'd0, 4'b0000, 16'h0, 16'h0);

        done = 1'b1;
        summary();
        $finish;
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule